// File: doc/BRIEF.md
# Video Link Transmit Formatter

This block sits on the transmit side of a serial video link. On every pixel clock it builds one parallel payload word for each of two lanes. The serializer downstream consumes these words. Each input pixel carries three 10-bit colour channels and two user bits. The data enable (DE) signal decides what a word carries. While DE is high, a lane word carries pixel data. While DE is low, it carries the two sync levels and, optionally, a small group of control bits. The control bits are suppressed on the first and on the last pixel of every blanking interval.

Deciding whether a blanking pixel is the last one requires the DE value of the next pixel. For that reason each pixel passes through one input stage before the output register is loaded. A two-bit mode input selects the lane arrangement:

- Two pixels onto two lanes.
- One pixel onto one lane.
- One pixel alternating across two lanes.

The fourth mode code is forbidden and is flagged. A DE timing monitor runs alongside the datapath and raises sticky flags when DE breaks the length or even-cycle rules. A low-active power-down input clears every register.

The DE monitor is a four-state machine:

- `ST_IDLE` is entered at power-down. It moves to `ST_SYNC_LOW` on the first low DE sample.
- `ST_SYNC_LOW` is a first blanking stretch whose length is not judged. It moves to `ST_ACTIVE` when DE is sampled high.
- `ST_ACTIVE` moves to `ST_BLANK` on a low sample (the falling transition). This transition judges the high length.
- `ST_BLANK` moves back to `ST_ACTIVE` on a high sample (the rising transition). This transition judges the low length and the rise-to-rise period.

The machine never returns to `ST_IDLE` until the next power-down.

Top module: `vtx_link_formatter`

## Requirements
- R1: With DE high, a lane word holds the pixel as R in bits [31:22], G in [21:12], B in [11:2] and the user bits in [1:0], and that lane's `lane_act` bit is 1.
- R2: With DE low, a lane word holds HSYNC in bit 0 and VSYNC in bit 1. Bits [5:2] hold `ctl_bits` when `ctl_en` is 1 and are 0 otherwise. All other bits are 0 and `lane_act` is 0.
- R3: Bits [5:2] are 0 on the first blanking pixel after a high DE and on the last blanking pixel before a high DE, whatever `ctl_en` is.
- R4: With `col8` = 1 (8-bit colour), bits [1:0] of an active word are 0.
- R5: A pixel sampled on rising edge k appears on the lane outputs just after rising edge k+1.
- R6: `mode_sel` = 00 puts pixel 0 on lane 0 and pixel 1 on lane 1, with `lane_vld` = 11. `mode_sel` = 01 puts pixel 0 on lane 0 with `lane_vld` = 01, and lane 1 is all zero.
- R7: `mode_sel` = 10 sends pixel 0 of successive active pixels to lane 0, lane 1, lane 0, and so on. Each high-DE stretch restarts on lane 0. Only the written lane has its `lane_vld` bit set, and the other lane holds its word. In blanking, both lanes carry the sync word with `lane_vld` = 11.
- R8: `mode_sel` = 11 raises `mode_err`, clears `lane_vld` and drives both words to zero, with the same latency as the payload.
- R9: `de_even_err` is set, and stays set, when a DE-high length or a rise-to-rise DE period is an odd number of cycles.
- R10: `de_len_err` is set, and stays set, when DE high lasts fewer than 2 cycles, or DE low lasts fewer than 2 cycles (4 cycles in mode 10).
- R11: `pdn_n` low clears the lane words, `lane_vld`, `lane_act`, `mode_err` and both DE flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| pdn_n | input | 1 | Power-down, active low, asynchronous clear |
| de | input | 1 | Data enable |
| hsync | input | 1 | Horizontal sync level |
| vsync | input | 1 | Vertical sync level |
| pix0_r | input | 10 | Pixel 0 red |
| pix0_g | input | 10 | Pixel 0 green |
| pix0_b | input | 10 | Pixel 0 blue |
| pix0_u | input | 2 | Pixel 0 user bits |
| pix1_r | input | 10 | Pixel 1 red |
| pix1_g | input | 10 | Pixel 1 green |
| pix1_b | input | 10 | Pixel 1 blue |
| pix1_u | input | 2 | Pixel 1 user bits |
| ctl_bits | input | 4 | Control bits sent in blanking |
| ctl_en | input | 1 | Enables control bits in blanking |
| col8 | input | 1 | 1 = 8-bit colour, 0 = 10-bit colour |
| mode_sel | input | 2 | Lane arrangement select |
| lane0_word | output | 32 | Lane 0 payload |
| lane1_word | output | 32 | Lane 1 payload |
| lane_vld | output | 2 | Per-lane word written this cycle |
| lane_act | output | 2 | Per-lane word holds active pixel data |
| mode_err | output | 1 | Forbidden mode in the output word |
| de_len_err | output | 1 | Sticky DE minimum-length violation |
| de_even_err | output | 1 | Sticky DE even-cycle violation |

## Verification
Lane words, `lane_vld`, `lane_act` and `mode_err` are due two rising edges after their pixel is sampled. The extra edge is spent waiting for the next DE value. The stimulus table therefore compares row j at the falling edge where row j+2 is about to be driven. The DE flags are due one edge after the sample that completes a transition. Because they are sticky, each DE pattern is preceded by a power-down, and the flags are read at a falling edge after the closing transition. All outputs are read at falling edges, so no result depends on process order at a rising edge.

// File: rtl/vtx_pkg.sv
package vtx_pkg;

    localparam int LANES = 2;

    typedef enum logic [1:0] {
        MODE_DIDO = 2'b00,
        MODE_SISO = 2'b01,
        MODE_SIDO = 2'b10,
        MODE_BAD  = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SYNC_LOW,
        ST_ACTIVE,
        ST_BLANK
    } de_state_e;

endpackage

// File: rtl/vtx_de_monitor.sv
module vtx_de_monitor
    import vtx_pkg::*;
#(
    parameter int CNT_W       = 12,
    parameter int MIN_HIGH    = 2,
    parameter int MIN_LOW     = 2,
    parameter int MIN_LOW_SPL = 4
) (
    input  logic clk,
    input  logic pdn_n,
    input  logic de,
    input  logic split_mode,
    output logic len_err,
    output logic even_err
);

    localparam logic [CNT_W-1:0] HI_MIN_C  = CNT_W'(MIN_HIGH);
    localparam logic [CNT_W-1:0] LO_MIN_C  = CNT_W'(MIN_LOW);
    localparam logic [CNT_W-1:0] LO_SPL_C  = CNT_W'(MIN_LOW_SPL);
    localparam logic [CNT_W-1:0] ONE_C     = CNT_W'(1);

    de_state_e        state_q, state_d;
    logic [CNT_W-1:0] run_q, run_d, run_inc;
    logic [CNT_W-1:0] per_q, per_d, per_inc;
    logic             len_q, len_d, even_q, even_d;
    logic [CNT_W-1:0] low_min;

    assign run_inc = (&run_q) ? run_q : run_q + ONE_C;
    assign per_inc = (&per_q) ? per_q : per_q + ONE_C;
    assign low_min = split_mode ? LO_SPL_C : LO_MIN_C;

    always_ff @(posedge clk or negedge pdn_n) begin
        if (!pdn_n) begin
            state_q <= ST_IDLE;
            run_q   <= '0;
            per_q   <= '0;
            len_q   <= 1'b0;
            even_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
            per_q   <= per_d;
            len_q   <= len_d;
            even_q  <= even_d;
        end
    end

    always_comb begin
        state_d = state_q;
        run_d   = run_inc;
        per_d   = per_inc;
        len_d   = len_q;
        even_d  = even_q;
        unique case (state_q)
            ST_IDLE: begin
                run_d = '0;
                per_d = '0;
                if (!de) state_d = ST_SYNC_LOW;
            end
            ST_SYNC_LOW: begin
                run_d = '0;
                per_d = '0;
                if (de) begin
                    state_d = ST_ACTIVE;
                    run_d   = ONE_C;
                    per_d   = ONE_C;
                end
            end
            ST_ACTIVE: begin
                if (!de) begin
                    state_d = ST_BLANK;
                    run_d   = ONE_C;
                    if (run_q[0])         even_d = 1'b1;
                    if (run_q < HI_MIN_C) len_d  = 1'b1;
                end
            end
            ST_BLANK: begin
                if (de) begin
                    state_d = ST_ACTIVE;
                    run_d   = ONE_C;
                    per_d   = ONE_C;
                    if (run_q < low_min) len_d  = 1'b1;
                    if (per_q[0])        even_d = 1'b1;
                end
            end
        endcase
    end

    assign len_err  = len_q;
    assign even_err = even_q;

    // R10: length flag holds until power-down
    assert_len_sticky_R10: assert property (@(posedge clk) disable iff (!pdn_n)
        len_q |=> len_q);

    // R9: parity flag holds until power-down
    assert_even_sticky_R9: assert property (@(posedge clk) disable iff (!pdn_n)
        even_q |=> even_q);

    // R10: a new length violation only follows a DE level change
    assert_len_on_edge_R10: assert property (@(posedge clk) disable iff (!pdn_n)
        $rose(len_q) |-> ($past(de) != ($past(state_q) == ST_ACTIVE)));

    // R9: machine leaves idle for good once it has seen DE low
    assert_no_idle_return_R9: assert property (@(posedge clk) disable iff (!pdn_n)
        (state_q != ST_IDLE) |=> (state_q != ST_IDLE));

endmodule

// File: rtl/vtx_lane_packer.sv
module vtx_lane_packer
    import vtx_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int USER_W = 2,
    parameter int CTL_W  = 4
) (
    input  logic                          clk,
    input  logic                          pdn_n,
    input  logic                          de,
    input  logic                          hsync,
    input  logic                          vsync,
    input  logic [WORD_W-1:0]             pix0,
    input  logic [WORD_W-1:0]             pix1,
    input  logic [CTL_W-1:0]              ctl_bits,
    input  logic                          ctl_en,
    input  logic                          col8,
    input  logic [1:0]                    mode_sel,
    output logic [LANES-1:0][WORD_W-1:0]  words,
    output logic [LANES-1:0]              vld,
    output logic [LANES-1:0]              act,
    output logic                          mode_err
);

    localparam int CTL_LSB = 2;

    // input stage
    logic                          s_de, s_hs, s_vs, s_ctl_en, s_col8, p_de;
    logic [LANES-1:0][WORD_W-1:0]  s_pix;
    logic [CTL_W-1:0]              s_ctl;
    logic [1:0]                    s_mode;
    logic                          phase_q;

    // output stage
    logic [LANES-1:0][WORD_W-1:0]  word_q, word_d;
    logic [LANES-1:0]              vld_q, vld_d, act_q, act_d;
    logic                          err_q, err_d;
    logic                          o_col8_q, o_de_q;
    logic [1:0]                    o_mode_q;

    logic                          first_blk, last_blk, first_act, sido_lane;
    logic [WORD_W-1:0]             blank_w;
    logic [LANES-1:0][WORD_W-1:0]  act_w;

    always_ff @(posedge clk or negedge pdn_n) begin
        if (!pdn_n) begin
            s_de     <= 1'b0;
            s_hs     <= 1'b0;
            s_vs     <= 1'b0;
            s_pix    <= '0;
            s_ctl    <= '0;
            s_ctl_en <= 1'b0;
            s_col8   <= 1'b0;
            s_mode   <= 2'b00;
            p_de     <= 1'b0;
        end else begin
            s_de     <= de;
            s_hs     <= hsync;
            s_vs     <= vsync;
            s_pix    <= {pix1, pix0};
            s_ctl    <= ctl_bits;
            s_ctl_en <= ctl_en;
            s_col8   <= col8;
            s_mode   <= mode_sel;
            p_de     <= s_de;
        end
    end

    assign first_blk = !s_de && p_de;
    assign last_blk  = !s_de && de;
    assign first_act = s_de && !p_de;
    assign sido_lane = first_act ? 1'b0 : ~phase_q;

    always_comb begin
        blank_w    = '0;
        blank_w[0] = s_hs;
        blank_w[1] = s_vs;
        if (s_ctl_en && !first_blk && !last_blk)
            blank_w[CTL_LSB +: CTL_W] = s_ctl;
    end

    for (genvar p = 0; p < LANES; p++) begin : g_act
        assign act_w[p] = s_col8 ? {s_pix[p][WORD_W-1:USER_W], {USER_W{1'b0}}}
                                 : s_pix[p];
    end

    always_comb begin
        word_d = word_q;
        vld_d  = '0;
        act_d  = act_q;
        err_d  = 1'b0;
        unique case (mode_e'(s_mode))
            MODE_DIDO: begin
                for (int l = 0; l < LANES; l++) begin
                    word_d[l] = s_de ? act_w[l] : blank_w;
                    act_d[l]  = s_de;
                end
                vld_d = '1;
            end
            MODE_SISO: begin
                word_d[0] = s_de ? act_w[0] : blank_w;
                act_d[0]  = s_de;
                word_d[1] = '0;
                act_d[1]  = 1'b0;
                vld_d     = 2'b01;
            end
            MODE_SIDO: begin
                if (s_de) begin
                    word_d[sido_lane] = act_w[0];
                    act_d[sido_lane]  = 1'b1;
                    vld_d[sido_lane]  = 1'b1;
                end else begin
                    for (int l = 0; l < LANES; l++) word_d[l] = blank_w;
                    act_d = '0;
                    vld_d = '1;
                end
            end
            MODE_BAD: begin
                word_d = '0;
                act_d  = '0;
                err_d  = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge pdn_n) begin
        if (!pdn_n) begin
            word_q   <= '0;
            vld_q    <= '0;
            act_q    <= '0;
            err_q    <= 1'b0;
            phase_q  <= 1'b0;
            o_col8_q <= 1'b0;
            o_de_q   <= 1'b0;
            o_mode_q <= 2'b00;
        end else begin
            word_q   <= word_d;
            vld_q    <= vld_d;
            act_q    <= act_d;
            err_q    <= err_d;
            o_col8_q <= s_col8;
            o_de_q   <= s_de;
            o_mode_q <= s_mode;
            if (s_de && (s_mode == MODE_SIDO)) phase_q <= sido_lane;
        end
    end

    assign words    = word_q;
    assign vld      = vld_q;
    assign act      = act_q;
    assign mode_err = err_q;

    // R8: forbidden mode never marks a lane written
    assert_bad_mode_quiet_R8: assert property (@(posedge clk) disable iff (!pdn_n)
        err_q |-> (vld_q == '0) && (word_q[0] == '0) && (word_q[1] == '0));

    // R3: blank word right after an active word on lane 0 has no control bits
    assert_first_blank_noctl_R3: assert property (@(posedge clk) disable iff (!pdn_n)
        (vld_q[0] && !act_q[0] && $past(vld_q[0] && act_q[0]))
            |-> (word_q[0][CTL_LSB +: CTL_W] == '0));

    // R4: 8-bit colour words carry no user bits
    assert_user_zero_R4: assert property (@(posedge clk) disable iff (!pdn_n)
        (vld_q[0] && act_q[0] && o_col8_q) |-> (word_q[0][USER_W-1:0] == '0));

    // R7: split mode writes exactly one lane per active pixel
    assert_split_onehot_R7: assert property (@(posedge clk) disable iff (!pdn_n)
        (o_de_q && (o_mode_q == MODE_SIDO)) |-> ($countones(vld_q) == 1));

endmodule

// File: rtl/vtx_link_formatter.sv
module vtx_link_formatter
    import vtx_pkg::*;
#(
    parameter int COLOR_W = 10,
    parameter int USER_W  = 2,
    parameter int CTL_W   = 4,
    parameter int CNT_W   = 12
) (
    input  logic                          clk,
    input  logic                          pdn_n,
    input  logic                          de,
    input  logic                          hsync,
    input  logic                          vsync,
    input  logic [COLOR_W-1:0]            pix0_r,
    input  logic [COLOR_W-1:0]            pix0_g,
    input  logic [COLOR_W-1:0]            pix0_b,
    input  logic [USER_W-1:0]             pix0_u,
    input  logic [COLOR_W-1:0]            pix1_r,
    input  logic [COLOR_W-1:0]            pix1_g,
    input  logic [COLOR_W-1:0]            pix1_b,
    input  logic [USER_W-1:0]             pix1_u,
    input  logic [CTL_W-1:0]              ctl_bits,
    input  logic                          ctl_en,
    input  logic                          col8,
    input  logic [1:0]                    mode_sel,
    output logic [3*COLOR_W+USER_W-1:0]   lane0_word,
    output logic [3*COLOR_W+USER_W-1:0]   lane1_word,
    output logic [1:0]                    lane_vld,
    output logic [1:0]                    lane_act,
    output logic                          mode_err,
    output logic                          de_len_err,
    output logic                          de_even_err
);

    localparam int WORD_W = 3*COLOR_W + USER_W;

    logic [LANES-1:0][WORD_W-1:0] words;

    vtx_lane_packer #(
        .WORD_W (WORD_W),
        .USER_W (USER_W),
        .CTL_W  (CTL_W)
    ) u_packer (
        .clk      (clk),
        .pdn_n    (pdn_n),
        .de       (de),
        .hsync    (hsync),
        .vsync    (vsync),
        .pix0     ({pix0_r, pix0_g, pix0_b, pix0_u}),
        .pix1     ({pix1_r, pix1_g, pix1_b, pix1_u}),
        .ctl_bits (ctl_bits),
        .ctl_en   (ctl_en),
        .col8     (col8),
        .mode_sel (mode_sel),
        .words    (words),
        .vld      (lane_vld),
        .act      (lane_act),
        .mode_err (mode_err)
    );

    vtx_de_monitor #(
        .CNT_W (CNT_W)
    ) u_monitor (
        .clk        (clk),
        .pdn_n      (pdn_n),
        .de         (de),
        .split_mode (mode_sel == MODE_SIDO),
        .len_err    (de_len_err),
        .even_err   (de_even_err)
    );

    assign lane0_word = words[0];
    assign lane1_word = words[1];

endmodule

// File: tb/test_vtx_link_formatter.sv
module test_vtx_link_formatter;

    logic        clk = 1'b0;
    logic        pdn_n;
    logic        de, hsync, vsync, ctl_en, col8;
    logic [9:0]  pix0_r, pix0_g, pix0_b, pix1_r, pix1_g, pix1_b;
    logic [1:0]  pix0_u, pix1_u, mode_sel;
    logic [3:0]  ctl_bits;
    logic [31:0] lane0_word, lane1_word;
    logic [1:0]  lane_vld, lane_act;
    logic        mode_err, de_len_err, de_even_err;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    vtx_link_formatter i_vtx_link_formatter (
        .clk(clk), .pdn_n(pdn_n), .de(de), .hsync(hsync), .vsync(vsync),
        .pix0_r(pix0_r), .pix0_g(pix0_g), .pix0_b(pix0_b), .pix0_u(pix0_u),
        .pix1_r(pix1_r), .pix1_g(pix1_g), .pix1_b(pix1_b), .pix1_u(pix1_u),
        .ctl_bits(ctl_bits), .ctl_en(ctl_en), .col8(col8), .mode_sel(mode_sel),
        .lane0_word(lane0_word), .lane1_word(lane1_word),
        .lane_vld(lane_vld), .lane_act(lane_act), .mode_err(mode_err),
        .de_len_err(de_len_err), .de_even_err(de_even_err)
    );

    // row: de, ctl_en, col8, mode[1:0], vld[1:0], lane0 code[2:0], lane1 code[2:0]
    // codes: 0 zero, 1 pixel0, 2 pixel1, 3 blank with ctl, 4 blank ctl cleared, 7 skip
    localparam int ROWS = 37;
    localparam logic [12:0] TBL [ROWS] = '{
        13'b0_1_0_00_11_011_011, 13'b0_1_0_00_11_011_011, 13'b0_1_0_00_11_100_100,
        13'b1_1_0_00_11_001_010, 13'b1_1_0_00_11_001_010, 13'b0_1_0_00_11_100_100,
        13'b0_1_0_00_11_011_011, 13'b0_1_0_00_11_011_011, 13'b0_1_0_00_11_100_100,
        13'b1_1_1_00_11_001_010, 13'b1_1_1_00_11_001_010, 13'b0_0_0_00_11_100_100,
        13'b0_0_0_00_11_100_100, 13'b0_0_0_00_11_100_100, 13'b1_1_0_01_01_001_000,
        13'b1_1_0_01_01_001_000, 13'b0_1_0_01_01_100_000, 13'b0_1_0_01_01_011_000,
        13'b0_1_0_01_01_011_000, 13'b0_1_0_01_01_100_000, 13'b1_1_0_10_01_001_111,
        13'b1_1_0_10_10_111_001, 13'b1_1_0_10_01_001_111, 13'b1_1_0_10_10_111_001,
        13'b0_1_0_10_11_100_100, 13'b0_1_0_10_11_011_011, 13'b0_1_0_10_11_011_011,
        13'b0_1_0_10_11_100_100, 13'b1_1_0_10_01_001_111, 13'b1_1_0_10_10_111_001,
        13'b0_1_0_10_11_100_100, 13'b0_1_0_10_11_011_011, 13'b0_1_0_10_11_011_011,
        13'b0_1_0_10_11_100_100, 13'b1_1_0_11_00_000_000, 13'b0_1_0_11_00_000_000,
        13'b0_1_0_00_11_011_011
    };

    function automatic logic [31:0] pixw(int i, int p, logic c8);
        logic [9:0] r, g, b;
        logic [1:0] u;
        r = 10'(i*37 + p*5 + 1);
        g = 10'(i*11 + p*3 + 2);
        b = 10'(i*13 + p + 3);
        u = c8 ? 2'b00 : 2'(i + p + 1);
        return {r, g, b, u};
    endfunction

    function automatic logic [3:0] ctlv(int i);
        return {1'b1, 3'(i)};
    endfunction

    function automatic logic [31:0] expw(int i, int code, logic c8);
        logic [1:0] sy;
        sy = {1'(i >> 1), 1'(i)};
        case (code)
            1:       return pixw(i, 0, c8);
            2:       return pixw(i, 1, c8);
            3:       return {26'b0, ctlv(i), sy};
            4:       return {26'b0, 4'b0, sy};
            default: return 32'b0;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] actv, logic [31:0] expv, string what);
        checks++;
        if (actv !== expv) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, actv, expv);
        end
    endtask

    function automatic string code_req(int code, logic c8);
        case (code)
            1, 2:    return c8 ? "R4" : "R1/R5";
            3:       return "R2";
            4:       return "R3";
            default: return "R6/R8";
        endcase
    endfunction

    task automatic drive_row(int i);
        logic [12:0] r;
        logic [31:0] a, b;
        r = (i < ROWS) ? TBL[i] : 13'b0_1_0_00_11_000_000;
        a = pixw(i, 0, 1'b0);
        b = pixw(i, 1, 1'b0);
        de = r[12]; ctl_en = r[11]; col8 = r[10]; mode_sel = r[9:8];
        hsync = 1'(i); vsync = 1'(i >> 1); ctl_bits = ctlv(i);
        {pix0_r, pix0_g, pix0_b, pix0_u} = a;
        {pix1_r, pix1_g, pix1_b, pix1_u} = b;
    endtask

    task automatic check_row(int j);
        logic [12:0] r;
        int c0, c1;
        string vreq;
        r  = TBL[j];
        c0 = int'(r[5:3]);
        c1 = int'(r[2:0]);
        vreq = (r[9:8] == 2'b10) ? "R7" : (r[9:8] == 2'b11) ? "R8" : "R6";
        check(vreq, 32'(lane_vld), 32'(r[7:6]), $sformatf("row %0d lane_vld", j));
        check("R8", 32'(mode_err), 32'(r[9:8] == 2'b11), $sformatf("row %0d mode_err", j));
        if (c0 != 7) begin
            check(code_req(c0, r[10]), lane0_word, expw(j, c0, r[10]), $sformatf("row %0d lane0", j));
            check("R1", 32'(lane_act[0]), 32'(c0 == 1 || c0 == 2), $sformatf("row %0d act0", j));
        end
        if (c1 != 7) begin
            check(code_req(c1, r[10]), lane1_word, expw(j, c1, r[10]), $sformatf("row %0d lane1", j));
            check("R1", 32'(lane_act[1]), 32'(c1 == 1 || c1 == 2), $sformatf("row %0d act1", j));
        end
    endtask

    task automatic de_pattern(logic [1:0] m, int hi, int lo, logic e_len, logic e_even, string req);
        @(negedge clk);
        pdn_n = 1'b0;
        @(negedge clk);
        pdn_n = 1'b1;
        mode_sel = m;
        de = 1'b0; repeat (3) @(negedge clk);
        de = 1'b1; repeat (hi) @(negedge clk);
        de = 1'b0; repeat (lo) @(negedge clk);
        de = 1'b1; repeat (2) @(negedge clk);
        de = 1'b0; repeat (2) @(negedge clk);
        check(req, 32'(de_len_err), 32'(e_len), $sformatf("len flag hi=%0d lo=%0d", hi, lo));
        check(req, 32'(de_even_err), 32'(e_even), $sformatf("even flag hi=%0d lo=%0d", hi, lo));
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL R5 watchdog: actual hung expected done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        pdn_n = 1'b0;
        drive_row(ROWS);
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11", lane0_word, 32'b0, "reset lane0");
        check("R11", lane1_word, 32'b0, "reset lane1");
        check("R11", 32'({lane_vld, lane_act, mode_err, de_len_err, de_even_err}), 32'b0, "reset flags");
        pdn_n = 1'b1;

        for (int i = 0; i < ROWS + 2; i++) begin
            @(negedge clk);
            if (i >= 2) check_row(i - 2);
            drive_row(i);
        end

        // DE timing directed cases
        de_pattern(2'b00, 2, 2, 1'b0, 1'b0, "R9/R10 legal");
        de_pattern(2'b00, 3, 2, 1'b0, 1'b1, "R9 odd high");
        de_pattern(2'b00, 1, 3, 1'b1, 1'b1, "R10 short high");
        de_pattern(2'b00, 2, 3, 1'b0, 1'b1, "R9 odd period");
        de_pattern(2'b00, 2, 1, 1'b1, 1'b1, "R10 short low");
        de_pattern(2'b10, 2, 2, 1'b1, 1'b0, "R10 split low 2");
        de_pattern(2'b10, 2, 4, 1'b0, 1'b0, "R10 split low 4");
        de_pattern(2'b01, 1, 2, 1'b1, 1'b1, "R10 single short");

        // R11: power-down clears the sticky flags and lanes mid-stream
        @(negedge clk);
        pdn_n = 1'b0;
        @(negedge clk);
        check("R11", 32'(de_len_err), 32'b0, "len flag after power-down");
        check("R11", 32'(de_even_err), 32'b0, "even flag after power-down");
        check("R11", lane0_word, 32'b0, "lane0 after power-down");
        check("R11", 32'(lane_vld), 32'b0, "vld after power-down");
        pdn_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule